// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block holds the active-lane mask of a single wavefront on a SIMD compute unit and handles structured divergence without per-lane program counters. A push strobe saves the current mask on a small stack, together with a reconvergence label. A conditional-mask strobe takes a per-lane truth vector and switches off every active lane whose value is zero. A loop is written as a push, then a body that narrows the mask, then a backward jump. Each pass narrows the mask further. When no lane is left active, the block pops the saved entry on its own, restores the saved mask, and redirects fetch to the stored label for one cycle. An explicit pop, used at the end of an if-block, restores the mask without a redirect.

A small state machine governs the block. ST_IDLE is the state after reset: the mask is zero and strobes are ignored. A wave-start strobe moves any state to ST_RUN. Transition T_START loads the launch mask, empties the stack and clears the errors. In ST_RUN, the transitions are:
- T_PUSH saves an entry.
- T_NARROW narrows the mask.
- T_AUTOPOP restores the mask and redirects.
- T_POP restores the mask without a redirect.
- T_OVF (push onto a full stack) and T_UNF (pop from an empty stack) lead to ST_FAULT.

ST_FAULT freezes the mask and holds the sticky error flags until the next wave start.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all zero and no error or redirect is raised. Push, conditional-mask and pop strobes have no effect until wave_start. A wave_start loads active_mask from launch_mask on the next cycle, empties the stack and clears both error flags.
- R2: A push saves the pair (current active mask, push_label) on the stack. The active mask does not change.
- R3: A conditional-mask operation sets the next active mask to active_mask AND cond_vec, where bit i of cond_vec is 1 when lane i's value is nonzero. The result is visible one cycle after the strobe.
- R4: When a conditional-mask operation leaves no lane active and the stack is not empty, the top entry is popped and its saved mask becomes the active mask on the next cycle.
- R5: On that automatic pop, redirect_valid is high for exactly the following cycle. During that cycle redirect_addr carries the label of the popped entry.
- R6: Whenever redirect_valid is low, redirect_addr equals the pc input.
- R7: An explicit pop restores the top entry's mask and does not raise redirect_valid.
- R8: A push while the stack holds DEPTH entries sets overflow_err and leaves the stack unchanged. The error is sticky, and all strobes are ignored (the mask is frozen) until the next wave_start.
- R9: An explicit or automatic pop on an empty stack sets underflow_err. The error is sticky, with the same freeze as in R8. An automatic pop on an empty stack leaves the mask all zero. An explicit pop on an empty stack leaves the mask unchanged.
- R10: When several strobes arrive in one cycle, the first in this order is acted on and the others are ignored: wave_start, push, conditional mask, pop.
- R11: Entries come off the stack in last-in, first-out order. Each restores the mask and label saved by its own push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wave_start | input | 1 | Begin a wavefront |
| launch_mask | input | LANES | Mask loaded on wave start |
| push_en | input | 1 | Push strobe |
| push_label | input | AW | Reconvergence label saved with the push |
| cond_en | input | 1 | Conditional-mask strobe |
| cond_vec | input | LANES | Per-lane nonzero flags |
| pop_en | input | 1 | Explicit pop strobe |
| pc | input | AW | Current program counter |
| active_mask | output | LANES | Current active-lane mask |
| redirect_valid | output | 1 | One-cycle redirect on automatic pop |
| redirect_addr | output | AW | Label when redirecting, pc otherwise |
| overflow_err | output | 1 | Sticky push-on-full error |
| underflow_err | output | 1 | Sticky pop-on-empty error |

## Verification
The narrowing function is swept exhaustively: every 8-bit condition vector is applied against several launch masks. This separates partial narrowing from the all-off case, which must pop, restore the mask and redirect to the label. Counted loops with per-lane trip counts, computed arithmetically for several patterns, show that narrowing accumulates across iterations and that the exit restores the launch mask exactly once. Nested push/pop sequences distinguish LIFO order and the explicit pop without redirect from the automatic pop. Same-cycle strobes, a push on a full stack and a pop on an empty stack exercise the priority order, the sticky errors and the freeze.

// File: rtl/simt_pkg.sv
package simt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } wave_state_t;
endpackage

// File: rtl/mask_narrow.sv
module mask_narrow #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] cur_mask,
    input  logic [LANES-1:0] lane_true,
    output logic [LANES-1:0] narrowed,
    output logic             all_off
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign narrowed[g] = cur_mask[g] & lane_true[g];
    end
    assign all_off = ~|narrowed;
endmodule

// File: rtl/mask_stack_mem.sv
module mask_stack_mem #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [LANES-1:0] wr_mask,
    input  logic [AW-1:0]    wr_label,
    output logic [LANES-1:0] top_mask,
    output logic [AW-1:0]    top_label,
    output logic             full,
    output logic             empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LANES-1:0] mask_mem  [DEPTH];
    logic [AW-1:0]    label_mem [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [IW-1:0]    wr_idx, rd_idx;

    assign wr_idx = IW'(cnt_q);
    assign rd_idx = IW'(cnt_q - CW'(1));
    assign full   = (cnt_q == CW'(DEPTH));
    assign empty  = (cnt_q == '0);

    assign top_mask  = empty ? '0 : mask_mem[rd_idx];
    assign top_label = empty ? '0 : label_mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_mem[e]  <= '0;
                label_mem[e] <= '0;
            end else if (!clr && push && !full && wr_idx == IW'(e)) begin
                mask_mem[e]  <= wr_mask;
                label_mem[e] <= wr_label;
            end
        end
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wave_start,
    input  logic [LANES-1:0] launch_mask,
    input  logic             push_en,
    input  logic [AW-1:0]    push_label,
    input  logic             cond_en,
    input  logic [LANES-1:0] cond_vec,
    input  logic             pop_en,
    input  logic [AW-1:0]    pc,
    output logic [LANES-1:0] active_mask,
    output logic             redirect_valid,
    output logic [AW-1:0]    redirect_addr,
    output logic             overflow_err,
    output logic             underflow_err
);
    wave_state_t      state_q, state_d;
    logic [LANES-1:0] mask_q, mask_d, narrowed, top_mask;
    logic [AW-1:0]    rlabel_q, rlabel_d, top_label;
    logic             all_off, full, empty;
    logic             do_push, do_pop, redir_q, redir_d;
    logic             ovf_q, unf_q, ovf_set, unf_set;
    logic             in_run;

    mask_narrow #(.LANES(LANES)) narrow_i (
        .cur_mask (mask_q),
        .lane_true(cond_vec),
        .narrowed (narrowed),
        .all_off  (all_off)
    );

    mask_stack_mem #(.LANES(LANES), .DEPTH(DEPTH), .AW(AW)) stack_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wave_start),
        .push     (do_push),
        .pop      (do_pop),
        .wr_mask  (mask_q),
        .wr_label (push_label),
        .top_mask (top_mask),
        .top_label(top_label),
        .full     (full),
        .empty    (empty)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d  = state_q;
        mask_d   = mask_q;
        rlabel_d = rlabel_q;
        redir_d  = 1'b0;
        do_push  = 1'b0;
        do_pop   = 1'b0;
        ovf_set  = 1'b0;
        unf_set  = 1'b0;
        if (wave_start) begin
            state_d = ST_RUN;                       // T_START
            mask_d  = launch_mask;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (push_en) begin
                        if (full) begin
                            ovf_set = 1'b1;         // T_OVF
                            state_d = ST_FAULT;
                        end else begin
                            do_push = 1'b1;         // T_PUSH
                        end
                    end else if (cond_en) begin
                        if (!all_off) begin
                            mask_d = narrowed;      // T_NARROW
                        end else if (empty) begin
                            unf_set = 1'b1;         // T_UNF
                            mask_d  = '0;
                            state_d = ST_FAULT;
                        end else begin
                            do_pop   = 1'b1;        // T_AUTOPOP
                            mask_d   = top_mask;
                            redir_d  = 1'b1;
                            rlabel_d = top_label;
                        end
                    end else if (pop_en) begin
                        if (empty) begin
                            unf_set = 1'b1;         // T_UNF
                            state_d = ST_FAULT;
                        end else begin
                            do_pop = 1'b1;          // T_POP
                            mask_d = top_mask;
                        end
                    end
                end
                ST_FAULT: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            redir_q  <= 1'b0;
            rlabel_q <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            mask_q   <= mask_d;
            redir_q  <= redir_d;
            rlabel_q <= rlabel_d;
            ovf_q    <= wave_start ? 1'b0 : (ovf_q | ovf_set);
            unf_q    <= wave_start ? 1'b0 : (unf_q | unf_set);
        end
    end

    assign in_run         = (state_q == ST_RUN);
    assign active_mask    = mask_q;
    assign redirect_valid = redir_q;
    assign redirect_addr  = redir_q ? rlabel_q : pc;
    assign overflow_err   = ovf_q;
    assign underflow_err  = unf_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
    parameter int LANES = 32,
    parameter int AW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wave_start,
    input logic [LANES-1:0] launch_mask,
    input logic             push_en,
    input logic             cond_en,
    input logic [AW-1:0]    pc,
    input logic [LANES-1:0] active_mask,
    input logic             redirect_valid,
    input logic [AW-1:0]    redirect_addr,
    input logic             overflow_err,
    input logic             underflow_err,
    input logic             in_run
);
    // R1
    a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wave_start |=> (active_mask == $past(launch_mask)) && !overflow_err && !underflow_err);

    // R2
    a_r2_push_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && push_en && !wave_start) |=> $stable(active_mask));

    // R3
    a_r3_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_run && cond_en && !push_en && !wave_start) |=>
            (redirect_valid || ((active_mask & ~$past(active_mask)) == '0)));

    // R5
    a_r5_redirect_from_cond: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> $past(cond_en));

    // R6
    a_r6_addr_is_pc: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |-> (redirect_addr == pc));

    // R8
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_err && !wave_start) |=> overflow_err);

    // R9
    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_err && !wave_start) |=> underflow_err);
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .AW(AW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wave_start    (wave_start),
    .launch_mask   (launch_mask),
    .push_en       (push_en),
    .cond_en       (cond_en),
    .pc            (pc),
    .active_mask   (active_mask),
    .redirect_valid(redirect_valid),
    .redirect_addr (redirect_addr),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err),
    .in_run        (in_run)
);

// File: tb/simt_mask_stack_tb_top.sv
module simt_mask_stack_tb_top;
    localparam int L  = 8;
    localparam int D  = 4;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wave_start = 1'b0;
    logic [L-1:0]  launch_mask = '0;
    logic          push_en = 1'b0;
    logic [AW-1:0] push_label = '0;
    logic          cond_en = 1'b0;
    logic [L-1:0]  cond_vec = '0;
    logic          pop_en = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [L-1:0]  active_mask;
    logic          redirect_valid;
    logic [AW-1:0] redirect_addr;
    logic          overflow_err, underflow_err;

    int nvec = 0;
    int nfail = 0;

    always #2 clk = ~clk;  // 250 MHz

    simt_mask_stack #(.LANES(L), .DEPTH(D), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wave_start(wave_start), .launch_mask(launch_mask),
        .push_en(push_en), .push_label(push_label), .cond_en(cond_en), .cond_vec(cond_vec),
        .pop_en(pop_en), .pc(pc), .active_mask(active_mask), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock edge with the given strobes; returns just after the edge.
    task automatic op(input logic ws, input logic [L-1:0] lm, input logic pu,
                      input logic [AW-1:0] lb, input logic ce, input logic [L-1:0] cv,
                      input logic po, input logic [AW-1:0] p);
        @(negedge clk);
        wave_start = ws; launch_mask = lm; push_en = pu; push_label = lb;
        cond_en = ce; cond_vec = cv; pop_en = po; pc = p;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input logic [AW-1:0] p);
        op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, p);
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [L-1:0] a, m, cv;
        logic [L-1:0] launches [4];
        int trip [L];
        launches[0] = 8'hFF; launches[1] = 8'hA5; launches[2] = 8'h3C; launches[3] = 8'h01;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 reset mask", active_mask, 0);
        chk("R1 reset errors", {overflow_err, underflow_err, redirect_valid}, 0);

        // R1: strobes ignored before start; pushed entry must not exist afterwards
        op(1'b0, '0, 1'b1, 8'h11, 1'b0, '0, 1'b0, 8'h00);
        chk("R1 idle push ignored mask", active_mask, 0);
        op(1'b1, 8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, 8'h00);
        chk("R1 start loads launch", active_mask, 8'hFF);
        op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 8'h01);
        chk("R9 pop empty underflow", underflow_err, 1);
        chk("R9 explicit pop empty keeps mask", active_mask, 8'hFF);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h0F, 1'b0, 8'h02);
        chk("R9 frozen after underflow", active_mask, 8'hFF);
        op(1'b1, 8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, 8'h00);
        chk("R1 start clears underflow", underflow_err, 0);

        // R11 / R7 / R4 / R5 / R6: nested regions
        op(1'b0, '0, 1'b1, 8'h40, 1'b0, '0, 1'b0, 8'h01);
        chk("R2 push keeps mask", active_mask, 8'hFF);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h0F, 1'b0, 8'h02);
        chk("R3 narrow outer", active_mask, 8'h0F);
        op(1'b0, '0, 1'b1, 8'h50, 1'b0, '0, 1'b0, 8'h03);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h33, 1'b0, 8'h04);
        chk("R3 narrow inner", active_mask, 8'h03);
        op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 8'h05);
        chk("R7 explicit pop mask", active_mask, 8'h0F);
        chk("R7 explicit pop no redirect", redirect_valid, 0);
        chk("R6 addr is pc", redirect_addr, 8'h05);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'hF0, 1'b0, 8'h06);
        chk("R11 outer restore", active_mask, 8'hFF);
        chk("R5 redirect raised", redirect_valid, 1);
        chk("R11 outer label", redirect_addr, 8'h40);
        idle(8'h41);
        chk("R5 redirect one cycle", redirect_valid, 0);
        chk("R6 addr back to pc", redirect_addr, 8'h41);

        // R10: push wins over cond; stack then holds one entry
        op(1'b0, '0, 1'b1, 8'h22, 1'b1, 8'h00, 1'b1, 8'h07);
        chk("R10 cond ignored under push", active_mask, 8'hFF);
        chk("R10 no redirect under push", redirect_valid, 0);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h3C, 1'b1, 8'h08);
        chk("R10 cond wins over pop", active_mask, 8'h3C);
        op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 8'h09);
        chk("R10 single entry pop", {underflow_err, active_mask}, {1'b0, 8'hFF});
        op(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b1, 8'h0A);
        chk("R10 second pop underflows", underflow_err, 1);
        op(1'b1, 8'h0F, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 8'h00);
        chk("R10 start wins", {underflow_err, active_mask}, {1'b0, 8'h0F});

        // R8: overflow
        for (int i = 0; i < D; i++) op(1'b0, '0, 1'b1, 8'(i), 1'b0, '0, 1'b0, 8'h00);
        chk("R8 full no error yet", overflow_err, 0);
        op(1'b0, '0, 1'b1, 8'h77, 1'b0, '0, 1'b0, 8'h00);
        chk("R8 overflow set", overflow_err, 1);
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h01, 1'b0, 8'h00);
        chk("R8 frozen after overflow", active_mask, 8'h0F);
        idle(8'h00);
        chk("R8 overflow sticky", overflow_err, 1);
        op(1'b1, 8'hFF, 1'b0, '0, 1'b0, '0, 1'b0, 8'h00);
        chk("R1 start clears overflow", overflow_err, 0);

        // R9: automatic pop on empty stack
        op(1'b0, '0, 1'b0, '0, 1'b1, 8'h00, 1'b0, 8'h00);
        chk("R9 auto pop empty underflow", underflow_err, 1);
        chk("R9 auto pop empty mask zero", active_mask, 0);

        // R3/R4/R5 exhaustive narrowing sweep
        for (int ai = 0; ai < 4; ai++) begin
            for (int c = 0; c < 256; c++) begin
                a = launches[ai];
                op(1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0, 8'h00);
                op(1'b0, '0, 1'b1, 8'(c), 1'b0, '0, 1'b0, 8'h01);
                op(1'b0, '0, 1'b0, '0, 1'b1, 8'(c), 1'b0, 8'h02);
                if ((a & 8'(c)) != 0) begin
                    chk("R3 sweep narrow", active_mask, a & 8'(c));
                    chk("R3 sweep no redirect", redirect_valid, 0);
                end else begin
                    chk("R4 sweep restore", active_mask, a);
                    chk("R5 sweep label", {redirect_valid, redirect_addr}, {1'b1, 8'(c)});
                end
            end
        end

        // Counted loops with per-lane trip counts
        for (int p = 0; p < 8; p++) begin
            a = launches[p % 4] | 8'(1 << p);
            for (int i = 0; i < L; i++) trip[i] = (i * (p + 1) + p) % 5 + 1;
            op(1'b1, a, 1'b0, '0, 1'b0, '0, 1'b0, 8'h00);
            op(1'b0, '0, 1'b1, 8'(8'h80 + p), 1'b0, '0, 1'b0, 8'h01);
            m = a;
            for (int k = 0; k < 8; k++) begin
                for (int i = 0; i < L; i++) cv[i] = (k < trip[i]);
                op(1'b0, '0, 1'b0, '0, 1'b1, cv, 1'b0, 8'h02);
                m = m & cv;
                if (m != 0) begin
                    chk("R3 loop iteration mask", active_mask, m);
                    idle(8'h03);  // body and backward jump
                end else begin
                    chk("R4 loop exit restore", active_mask, a);
                    chk("R5 loop exit label", {redirect_valid, redirect_addr},
                        {1'b1, 8'(8'h80 + p)});
                    break;
                end
            end
            idle(8'h10);
            chk("R5 loop redirect cleared", redirect_valid, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule